// File: doc/BRIEF.md
# Serial Shift Register with Strobed Holding Stage and Bus Outputs

This block takes a serial bit stream into an eight-stage shift chain that advances on every rising clock edge. Behind the chain sits a holding stage built as a level-sensitive latch. While the strobe input is high, the latch is open and the parallel outputs follow the chain. When the strobe drops, the latch keeps the last word it passed. The parallel outputs are three-state and can sit directly on a shared bus. An output-enable input decides whether they drive or float. A separate drive-enable output reports that same state, so a bench or a bus arbiter can observe it without resolving the net.

Two serial outputs let several of these registers form a longer chain. The first serial output is the last stage of the chain, and it changes on the rising edge. The second serial output carries the same bit, captured again on the following falling edge, which gives a downstream register half a clock period of extra hold margin. A synchronous clear input exists only to give simulation a defined start, and a system ties it low in normal use.

Top module: `shift_store_reg`

## Requirements
- R1: On each rising clock edge, stage 0 loads serIn and stage k (k ≥ 1) loads the previous value of stage k-1. parOut bit k shows stage k, so bit 0 holds the newest bit.
- R2: While strobe is 1, the holding stage follows the chain, including changes of strobe between clock edges. While strobe is 0, the holding stage keeps its value across rising edges.
- R3: With outEn = 1, parDrive is 1 and parOut equals the holding stage. With outEn = 0, parDrive is 0 and parOut is high impedance.
- R4: strobe and outEn have no effect on shifting. The chain and serOutRise keep advancing while the latch is closed or the bus floats.
- R5: serOutRise equals the last stage (stage 7) and changes only on rising edges.
- R6: serOutFall takes the value of stage 7 on each falling edge, and it holds that value through the next rising edge.
- R7: A falling edge changes neither the chain, serOutRise, nor parOut.
- R8: A rising edge with clr = 1 sets every stage and serOutRise to 0. The next falling edge sets serOutFall to 0.
- R9: When two instances are chained, one feeding the next through either serial output, 16 rising edges place a 16-bit word shifted in MSB first on the combined parallel outputs, with the upstream register holding the low 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| clr | input | 1 | Synchronous clear, active high, tied low in use |
| serIn | input | 1 | Serial data in |
| strobe | input | 1 | Holding-latch transparency control |
| outEn | input | 1 | Parallel bus drive enable |
| parOut | output | WIDTH | Three-state parallel outputs |
| parDrive | output | 1 | High when parOut is driven |
| serOutRise | output | 1 | Last stage, rising-edge timing |
| serOutFall | output | 1 | Last stage, retimed to the falling edge |

## Verification
The hardest condition to reach is a holding stage that diverges from the chain while shifting goes on behind a closed latch or a floating bus. Only that condition shows that strobe and outEn never gate the clock path. The stimulus table closes the latch and drops outEn across several edges of different data, then reopens the latch between clock edges, and compares against a reference model of chain and latch. The falling-edge output is checked half a period after each rising edge. Two pairs of chained instances, one pair cascaded through each serial output, check the 16-bit result.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  typedef struct packed {
    logic clearNow;
    logic latchOpen;
    logic busDrive;
  } ssrCtl_t;
endpackage

// File: rtl/ssr_ctrl.sv
module ssr_ctrl
  import ssr_pkg::*;
(
  input  logic    clr,
  input  logic    strobe,
  input  logic    outEn,
  output ssrCtl_t ctl
);
  always_comb begin
    ctl.clearNow  = clr;
    ctl.latchOpen = strobe;
    ctl.busDrive  = outEn;
  end
endmodule

// File: rtl/ssr_datapath.sv
module ssr_datapath
  import ssr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             serIn,
  input  ssrCtl_t          ctl,
  output logic [WIDTH-1:0] store,
  output logic             lastRise,
  output logic             lastFall
);
  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] chain;

  // stage 0 takes the serial input; later stages take their neighbour
  always_ff @(posedge clk) begin
    if (ctl.clearNow) chain[0] <= 1'b0;
    else              chain[0] <= serIn;
  end

  for (genvar k = 1; k < WIDTH; k++) begin : gStage
    always_ff @(posedge clk) begin
      if (ctl.clearNow) chain[k] <= 1'b0;
      else              chain[k] <= chain[k-1];
    end
  end

  // level-sensitive holding stage
  always_latch begin
    if (ctl.latchOpen) store = chain;
  end

  assign lastRise = chain[LAST];

  // half-period retimed copy of the last stage
  always_ff @(negedge clk) begin
    if (ctl.clearNow) lastFall <= 1'b0;
    else              lastFall <= chain[LAST];
  end

  assert_load_R1: assert property (@(posedge clk) disable iff (ctl.clearNow)
    !ctl.clearNow |=> (chain[0] == $past(serIn)))
    else $error("stage 0 missed serial input");

  assert_hold_R2: assert property (@(posedge clk) disable iff (ctl.clearNow)
    (!ctl.latchOpen && $past(!ctl.latchOpen)) |-> $stable(store))
    else $error("closed latch changed");

  assert_pass_R2: assert property (@(posedge clk) disable iff (ctl.clearNow)
    (ctl.latchOpen && $past(ctl.latchOpen)) |-> (store == chain))
    else $error("open latch not following chain");

  assert_retime_R6: assert property (@(posedge clk) disable iff (ctl.clearNow)
    lastFall == lastRise)
    else $error("falling copy disagrees with rising output");

  assert_clear_R8: assert property (@(posedge clk)
    $past(ctl.clearNow) |-> (chain == '0))
    else $error("clear left chain nonzero");
endmodule

// File: rtl/shift_store_reg.sv
module shift_store_reg
  import ssr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             serIn,
  input  logic             strobe,
  input  logic             outEn,
  output logic [WIDTH-1:0] parOut,
  output logic             parDrive,
  output logic             serOutRise,
  output logic             serOutFall
);
  ssrCtl_t          ctl;
  logic [WIDTH-1:0] store;

  ssr_ctrl u_ctrl (
    .clr    (clr),
    .strobe (strobe),
    .outEn  (outEn),
    .ctl    (ctl)
  );

  ssr_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .serIn    (serIn),
    .ctl      (ctl),
    .store    (store),
    .lastRise (serOutRise),
    .lastFall (serOutFall)
  );

  assign parDrive = ctl.busDrive;
  assign parOut   = ctl.busDrive ? store : {WIDTH{1'bz}};
endmodule

// File: tb/sim_shift_store_reg.sv
`timescale 1ns/1ps
module sim_shift_store_reg;
  logic clk = 1'b0;
  logic clr, serIn, strobe, outEn;
  wire  [7:0] parOut, par1, par2, par3;
  logic parDrive, qs1, qs2;
  logic d1, q1a, q1b, d2, q2a, q2b, d3, q3a, q3b;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  shift_store_reg u0 (.clk(clk), .clr(clr), .serIn(serIn), .strobe(strobe), .outEn(outEn),
    .parOut(parOut), .parDrive(parDrive), .serOutRise(qs1), .serOutFall(qs2));
  // cascade through rising-edge output
  shift_store_reg u1 (.clk(clk), .clr(clr), .serIn(qs1), .strobe(1'b1), .outEn(1'b1),
    .parOut(par1), .parDrive(d1), .serOutRise(q1a), .serOutFall(q1b));
  // cascade through falling-edge output
  shift_store_reg u2 (.clk(clk), .clr(clr), .serIn(serIn), .strobe(1'b1), .outEn(1'b1),
    .parOut(par2), .parDrive(d2), .serOutRise(q2a), .serOutFall(q2b));
  shift_store_reg u3 (.clk(clk), .clr(clr), .serIn(q2b), .strobe(1'b1), .outEn(1'b1),
    .parOut(par3), .parDrive(d3), .serOutRise(q3a), .serOutFall(q3b));

  logic [7:0] mChain, mStore;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkBus(input string req);
    chk(req, {15'd0, parDrive}, {15'd0, outEn});
    if (outEn) chk(req, {8'd0, parOut}, {8'd0, mStore});
  endtask

  // stimulus: {serIn, strobe, outEn}
  localparam logic [2:0] VEC [0:19] = '{
    3'b111, 3'b011, 3'b111, 3'b111, 3'b011, 3'b111, 3'b011, 3'b011,
    3'b101, 3'b001, 3'b100, 3'b000, 3'b110, 3'b010, 3'b111, 3'b001,
    3'b101, 3'b011, 3'b110, 3'b111
  };

  initial begin
    clr = 1'b1; serIn = 1'b1; strobe = 1'b1; outEn = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    mChain = '0; mStore = '0;
    chk("R8 chain clear", {8'd0, parOut}, 16'd0);
    chk("R8 rise out clear", {15'd0, qs1}, 16'd0);
    chk("R8 fall out clear", {15'd0, qs2}, 16'd0);
    clr = 1'b0;

    foreach (VEC[i]) begin
      {serIn, strobe, outEn} = VEC[i];
      #0.5;
      if (strobe) mStore = mChain;
      chkBus("R2/R3 between edges");
      @(posedge clk);
      mChain = {mChain[6:0], serIn};
      if (strobe) mStore = mChain;
      #1;
      chkBus("R1/R2/R3 after rise");
      chk("R4/R5 rise out", {15'd0, qs1}, {15'd0, mChain[7]});
      @(negedge clk);
      #1;
      chk("R6 fall out", {15'd0, qs2}, {15'd0, mChain[7]});
      chk("R7 rise out steady", {15'd0, qs1}, {15'd0, mChain[7]});
      chkBus("R7 bus steady");
      #1;
    end

    // R2: reopen the latch between edges
    strobe = 1'b0; outEn = 1'b1; serIn = 1'b0;
    @(posedge clk); mChain = {mChain[6:0], 1'b0};
    #2;
    chk("R2 held", {8'd0, parOut}, {8'd0, mStore});
    strobe = 1'b1; #1; mStore = mChain;
    chk("R2 reopen", {8'd0, parOut}, {8'd0, mStore});

    // R9 cascade with a 16-bit word, MSB first
    begin
      logic [15:0] word = 16'hB36D;
      for (int b = 15; b >= 0; b--) begin
        serIn = word[b];
        @(posedge clk); #2;
      end
      chk("R9 rise cascade", {par1, parOut}, word);
      chk("R9 fall cascade", {par3, par2}, word);
    end

    // R8 clear mid-run
    clr = 1'b1;
    @(posedge clk); #2;
    chk("R8 clear mid-run", {7'd0, qs1, parOut}, 16'd0);
    @(negedge clk); #1;
    chk("R8 fall clear", {15'd0, qs2}, 16'd0);
    clr = 1'b0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule